// File: doc/BRIEF.md
# Load/Store Fault Checker

The block examines every data load or store as it is issued and decides whether it must fault. Two faults are detected: a misaligned access (a halfword or word whose address is not a multiple of its size) and a stack access whose address leaves an inclusive window bounded by a low and a high limit. When a fault is found, the offending address and a 32-bit syndrome word are captured one clock later. If exceptions are enabled, a one-cycle exception request is raised at the same time.

The syndrome records the fault cause in its low bits. For a misalignment it also records the access direction, the destination register index and whether the access was word-sized. Capture happens whether or not exceptions are enabled, so a handler or a later poll always sees the most recent fault. The request is driven by a two-state machine. `ST_QUIET` moves to `ST_RAISE` on the transition *fault_taken*, which is a valid faulting access with exceptions enabled. `ST_RAISE` returns to `ST_QUIET` on *pulse_done* unless another enabled fault arrives, in which case *fault_again* keeps it in `ST_RAISE`. Every other case is *stay_quiet*.

Top module: `dacc_fault_chk`

## Requirements
- R1: After reset, `fault_addr` and `fault_synd` are zero and `exc_req` is low.
- R2: An access is misaligned when `acc_addr` ANDed with its size mask is nonzero. The `acc_size` encoding is 2'b00 byte (mask 0), 2'b01 halfword (mask 1), 2'b10 word (mask 3), and 2'b11 is treated as a word (mask 3).
- R3: A misaligned access writes the syndrome as follows: bits 4:0 = 1 (unaligned cause), bits 9:5 = `acc_reg`, bit 10 = `acc_write`, bit 11 = 1 for a word access and 0 for a halfword access, and bits 31:12 = 0.
- R4: On any fault, `fault_addr` takes the faulting `acc_addr`. The new value is visible from the clock edge that samples the access.
- R5: `exc_req` is high for exactly the cycle after a faulting access sampled with `exc_enable` = 1. With `exc_enable` = 0 it stays low, while the address and syndrome are still captured.
- R6: An access with `acc_stack` = 1 faults when its address is below `stk_low` or above `stk_high` (both limits are legal addresses). The syndrome is then exactly 7 (the stack cause).
- R7: The stack window is not checked when `acc_stack` = 0.
- R8: When an access is both misaligned and outside the stack window, the misalignment syndrome is written.
- R9: A cycle with no valid access, or a valid access that does not fault, leaves `fault_addr` and `fault_synd` unchanged and does not raise `exc_req`.
- R10: A byte access never produces an alignment fault, at any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_size | input | 2 | Access size code |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_reg | input | 5 | Destination or source register index |
| acc_stack | input | 1 | Access is a stack access |
| stk_low | input | ADDR_W | Lowest legal stack address |
| stk_high | input | ADDR_W | Highest legal stack address |
| exc_enable | input | 1 | Exceptions enabled |
| fault_addr | output | ADDR_W | Captured faulting address |
| fault_synd | output | 32 | Captured syndrome word |
| exc_req | output | 1 | Exception request pulse |

## Verification
The alignment check is exercised with aligned word, halfword and byte accesses and with misaligned halfword, word and reserved-size accesses. These patterns separate a wrong size mask from a wrong size-bit encoding in the syndrome. Stack accesses are placed exactly on both limits and one word outside each limit, which exposes an off-by-one or a wrong comparison direction. A non-stack access outside the window confirms that the stack check is gated by `acc_stack`, and a misaligned stack access outside the window distinguishes the two cause priorities. Repeating a misalignment with exceptions disabled shows that capture and request are independent.

// File: rtl/dafc_pkg.sv
package dafc_pkg;

    localparam int SYND_W   = 32;
    localparam int REGIDX_W = 5;
    localparam int CAUSE_W  = 5;

    localparam logic [CAUSE_W-1:0] CAUSE_UNALIGNED = 5'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_STACK     = 5'd7;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_RAISE = 1'b1
    } req_state_e;

    typedef struct packed {
        logic [SYND_W-CAUSE_W-REGIDX_W-3:0] zero;
        logic                               word_sz;
        logic                               is_store;
        logic [REGIDX_W-1:0]                reg_idx;
        logic [CAUSE_W-1:0]                 cause;
    } synd_t;

endpackage

// File: rtl/dafc_align_chk.sv
module dafc_align_chk
    import dafc_pkg::*;
(
    input  logic [1:0] addr_lsb,
    input  acc_size_e  size,
    output logic       misaligned,
    output logic       word_sized
);

    logic [1:0] size_mask;

    always_comb begin
        case (size)
            SZ_BYTE: size_mask = 2'b00;
            SZ_HALF: size_mask = 2'b01;
            default: size_mask = 2'b11;
        endcase
        misaligned = |(addr_lsb & size_mask);
        word_sized = (size == SZ_WORD) || (size == SZ_RSVD);
    end

endmodule

// File: rtl/dafc_stack_chk.sv
module dafc_stack_chk #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lim_lo,
    input  logic [ADDR_W-1:0] lim_hi,
    input  logic              is_stack,
    output logic              violation
);

    logic below;
    logic above;

    always_comb begin
        below     = addr < lim_lo;
        above     = addr > lim_hi;
        violation = is_stack && (below || above);
    end

endmodule

// File: rtl/dafc_synd_build.sv
module dafc_synd_build
    import dafc_pkg::*;
(
    input  logic                misaligned,
    input  logic                word_sized,
    input  logic                stack_viol,
    input  logic                is_store,
    input  logic [REGIDX_W-1:0] reg_idx,
    output logic                fault,
    output synd_t               synd
);

    always_comb begin
        synd  = '0;
        fault = misaligned || stack_viol;
        if (misaligned) begin
            // misalignment outranks the stack window
            synd.cause    = CAUSE_UNALIGNED;
            synd.reg_idx  = reg_idx;
            synd.is_store = is_store;
            synd.word_sz  = word_sized;
        end else if (stack_viol) begin
            synd.cause = CAUSE_STACK;
        end
    end

endmodule

// File: rtl/dacc_fault_chk.sv
module dacc_fault_chk
    import dafc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    input  logic [4:0]        acc_reg,
    input  logic              acc_stack,
    input  logic [ADDR_W-1:0] stk_low,
    input  logic [ADDR_W-1:0] stk_high,
    input  logic              exc_enable,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [31:0]       fault_synd,
    output logic              exc_req
);

    logic       misal;
    logic       word_sz;
    logic       stk_viol;
    logic       fault;
    synd_t      synd_nxt;
    req_state_e state_q;
    req_state_e state_d;
    logic       take;

    dafc_align_chk u_align (
        .addr_lsb   (acc_addr[1:0]),
        .size       (acc_size_e'(acc_size)),
        .misaligned (misal),
        .word_sized (word_sz)
    );

    dafc_stack_chk #(.ADDR_W(ADDR_W)) u_stack (
        .addr      (acc_addr),
        .lim_lo    (stk_low),
        .lim_hi    (stk_high),
        .is_stack  (acc_stack),
        .violation (stk_viol)
    );

    dafc_synd_build u_synd (
        .misaligned (misal),
        .word_sized (word_sz),
        .stack_viol (stk_viol),
        .is_store   (acc_write),
        .reg_idx    (acc_reg),
        .fault      (fault),
        .synd       (synd_nxt)
    );

    assign take = acc_valid && fault;

    // next-state logic
    always_comb begin
        state_d = ST_QUIET;
        unique case (state_q)
            ST_QUIET: state_d = (take && exc_enable) ? ST_RAISE : ST_QUIET; // fault_taken / stay_quiet
            ST_RAISE: state_d = (take && exc_enable) ? ST_RAISE : ST_QUIET; // fault_again / pulse_done
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // captured fault record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_addr <= '0;
            fault_synd <= '0;
        end else if (take) begin
            fault_addr <= acc_addr;
            fault_synd <= synd_nxt;
        end
    end

    // outputs
    always_comb begin
        exc_req = 1'b0;
        unique case (state_q)
            ST_QUIET: exc_req = 1'b0;
            ST_RAISE: exc_req = 1'b1;
        endcase
    end

endmodule

// File: rtl/dafc_fault_chk_sva.sv
module dafc_fault_chk_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic              acc_stack,
    input logic [ADDR_W-1:0] stk_low,
    input logic [ADDR_W-1:0] stk_high,
    input logic              exc_enable,
    input logic [ADDR_W-1:0] fault_addr,
    input logic [31:0]       fault_synd,
    input logic              exc_req
);

    AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(acc_valid && exc_enable)); // R5

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !exc_enable) |=> !exc_req); // R5

    AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (fault_addr == $past(acc_addr))); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> ($stable(fault_addr) && $stable(fault_synd) && !exc_req)); // R9

    AST_BYTE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_size == 2'b00 && !acc_stack) |=> (!exc_req && $stable(fault_synd))); // R10

    AST_STACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_stack && acc_size == 2'b00 &&
         (acc_addr < stk_low || acc_addr > stk_high)) |=> (fault_synd == 32'd7)); // R6

endmodule

bind dacc_fault_chk dafc_fault_chk_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/test_dacc_fault_chk.sv
`timescale 1ns/1ps
module test_dacc_fault_chk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_write = 1'b0;
    logic [4:0]  acc_reg = '0;
    logic        acc_stack = 1'b0;
    logic [31:0] stk_low = '0;
    logic [31:0] stk_high = 32'hFFFF_FFFF;
    logic        exc_enable = 1'b0;
    logic [31:0] fault_addr;
    logic [31:0] fault_synd;
    logic        exc_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dacc_fault_chk i_dacc_fault_chk (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] unal(input logic wr, input logic [4:0] r, input logic wd);
        return {20'd0, wd, wr, r, 5'd1};
    endfunction

    // drives one access at a negedge, returns at the next negedge
    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                          input logic [4:0] r, input logic stk, input logic en);
        acc_addr = a; acc_size = sz; acc_write = wr; acc_reg = r;
        acc_stack = stk; exc_enable = en; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 addr", fault_addr, 32'd0);
        chk("R1 synd", fault_synd, 32'd0);
        chk("R1 req", {31'd0, exc_req}, 32'd0);
    endtask

    task automatic t_aligned;
        access(32'h100, 2'b10, 1'b0, 5'd3, 1'b0, 1'b1);
        chk("R2 aligned word req", {31'd0, exc_req}, 32'd0);
        access(32'h102, 2'b01, 1'b1, 5'd3, 1'b0, 1'b1);
        chk("R2 aligned half req", {31'd0, exc_req}, 32'd0);
        access(32'h103, 2'b00, 1'b0, 5'd3, 1'b0, 1'b1);
        chk("R10 byte odd req", {31'd0, exc_req}, 32'd0);
        chk("R9 synd unchanged", fault_synd, 32'd0);
        chk("R9 addr unchanged", fault_addr, 32'd0);
    endtask

    task automatic t_misal_half;
        access(32'h1001, 2'b01, 1'b1, 5'd13, 1'b0, 1'b1);
        chk("R3 half synd", fault_synd, unal(1'b1, 5'd13, 1'b0));
        chk("R4 half addr", fault_addr, 32'h1001);
        chk("R5 req high", {31'd0, exc_req}, 32'd1);
        @(negedge clk);
        chk("R5 req one cycle", {31'd0, exc_req}, 32'd0);
        chk("R9 idle hold synd", fault_synd, unal(1'b1, 5'd13, 1'b0));
    endtask

    task automatic t_misal_word;
        access(32'h2002, 2'b10, 1'b0, 5'd31, 1'b0, 1'b1);
        chk("R3 word synd", fault_synd, unal(1'b0, 5'd31, 1'b1));
        chk("R4 word addr", fault_addr, 32'h2002);
        access(32'h0003, 2'b11, 1'b1, 5'd2, 1'b0, 1'b1);
        chk("R2 rsvd size synd", fault_synd, unal(1'b1, 5'd2, 1'b1));
        chk("R5 back-to-back req", {31'd0, exc_req}, 32'd1);
    endtask

    task automatic t_disabled;
        access(32'h77, 2'b01, 1'b0, 5'd4, 1'b0, 1'b0);
        chk("R5 disabled synd", fault_synd, unal(1'b0, 5'd4, 1'b0));
        chk("R5 disabled addr", fault_addr, 32'h77);
        chk("R5 disabled req", {31'd0, exc_req}, 32'd0);
    endtask

    task automatic t_stack;
        stk_low = 32'h1000; stk_high = 32'h1FFC;
        access(32'h1000, 2'b10, 1'b0, 5'd1, 1'b1, 1'b1);
        chk("R6 low limit legal", fault_synd, unal(1'b0, 5'd4, 1'b0));
        access(32'h1FFC, 2'b10, 1'b1, 5'd1, 1'b1, 1'b1);
        chk("R6 high limit legal", {31'd0, exc_req}, 32'd0);
        chk("R6 high limit addr", fault_addr, 32'h77);
        access(32'h0FFC, 2'b10, 1'b0, 5'd1, 1'b1, 1'b1);
        chk("R6 below synd", fault_synd, 32'd7);
        chk("R6 below addr", fault_addr, 32'h0FFC);
        chk("R6 below req", {31'd0, exc_req}, 32'd1);
        access(32'h2000, 2'b10, 1'b1, 5'd1, 1'b1, 1'b1);
        chk("R6 above synd", fault_synd, 32'd7);
        chk("R6 above addr", fault_addr, 32'h2000);
        access(32'h3000, 2'b10, 1'b0, 5'd1, 1'b0, 1'b1);
        chk("R7 non-stack req", {31'd0, exc_req}, 32'd0);
        chk("R7 non-stack addr", fault_addr, 32'h2000);
    endtask

    task automatic t_priority;
        access(32'h2001, 2'b01, 1'b1, 5'd9, 1'b1, 1'b1);
        chk("R8 priority synd", fault_synd, unal(1'b1, 5'd9, 1'b0));
        chk("R8 priority addr", fault_addr, 32'h2001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_aligned();
        t_misal_half();
        t_misal_word();
        t_disabled();
        t_stack();
        t_priority();
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule